// File: doc/BRIEF.md
# MDIO Management Master

This block sends clause-22 management frames to up to a handful of attached PHYs. It has one 32-bit control and status word on a simple register bus. A single write supplies the target PHY, the register index, the direction, the write data and a start flag. The block then runs the frame on the management clock and data lines. On a read it returns the received halfword in the low sixteen bits of that same word.

The busy bit acts as both start request and status. Software sets it to launch a frame and polls it until the block clears it. While a frame is running, the word is frozen and writes are dropped. MDC is the system clock divided by `CLK_DIV`. MDIO changes just after MDC falls and is sampled on MDC rising.

Control word layout: bits 15:0 hold the data, bits 20:16 the register index and bits 25:21 the PHY address. Bit 27 set selects a read and bit 27 clear selects a write. Bit 30 is the master enable and bit 31 is the busy/start bit. Bits 26, 28 and 29 read as zero.

Top module: `mdio_master`

## Requirements
- R1: After reset the control word reads 0, `mdc_o` is low and `mdio_oe_o` is low.
- R2: A write made while idle with bits 31 and 30 set and a PHY address below `NUM_PHYS` starts a frame. Bit 31 reads 1 from the next cycle.
- R3: A frame is 64 MDC cycles, each bit valid at the MDC rising edge. The order is: 32 ones, start bits 0 then 1, opcode 1,0 for a read or 0,1 for a write, the five PHY address bits, then the five register bits, each field MSB first.
- R4: On a write the master drives the turnaround as 1 then 0, then the 16 bits of bits 15:0, MSB first, with `mdio_oe_o` high for all 64 bits.
- R5: On a read, `mdio_oe_o` is high for the first 46 bits and low for the two turnaround bits and the 16 data bits.
- R6: On a read, the 16 values of `mdio_i` sampled on the last 16 MDC rising edges, MSB first, land in bits 15:0.
- R7: When the frame ends, bit 31 clears and all other stored fields keep their values.
- R8: MDC has a period of `CLK_DIV` clocks while a frame runs and is low while idle. `mdio_o` changes only on an MDC falling edge.
- R9: A write made while bit 31 reads 1 is ignored: the word, the frame on the wire and its length are unchanged.
- R10: A start write with bit 30 clear does not set busy and produces no MDC edge.
- R11: A start write with a PHY address of `NUM_PHYS` or above does not set busy and produces no MDC edge.
- R12: A write made while idle without bit 31 stores the other fields, so they read back, and starts no frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Write strobe for the control word |
| reg_wdata_i | input | 32 | Write data for the control word |
| reg_rdata_o | output | 32 | Current control and status word |
| mdc_o | output | 1 | Management clock |
| mdio_o | output | 1 | Management data output value |
| mdio_oe_o | output | 1 | Management data output enable |
| mdio_i | input | 1 | Management data input from the pad |

## Verification
The bench builds the block with `CLK_DIV` = 4 and `NUM_PHYS` = 5. The short divider makes each frame 256 clocks, so many full frames fit in the run, and the bench measures the MDC period exactly from rising-edge timestamps. With `NUM_PHYS` = 5, the highest legal address (4) and the lowest illegal one (5) are both exercised. A PHY model in the bench decodes every rising edge, checks the output enable pattern bit by bit, and drives read data on falling edges.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int DATA_W     = 16;
  localparam int ADDR_W     = 5;
  localparam int REG_LSB    = 16;
  localparam int PHY_LSB    = 21;
  localparam int RD_BIT     = 27;
  localparam int EN_BIT     = 30;
  localparam int BUSY_BIT   = 31;
  localparam int FRAME_LEN  = 64;
  localparam int TA_POS     = 46;
  localparam int DATA_POS   = 48;
  localparam int CNT_W      = $clog2(FRAME_LEN + 1);

  typedef struct packed {
    logic [ADDR_W-1:0] phy;
    logic [ADDR_W-1:0] regi;
    logic              rd;
    logic [DATA_W-1:0] data;
  } mdio_cmd_t;
endpackage

// File: rtl/mdio_clk_div.sv
module mdio_clk_div #(
  parameter int CLK_DIV = 8
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic mdc_o,
  output logic rise_o,
  output logic fall_o
);
  localparam int HALF = CLK_DIV / 2;
  localparam int CW   = (HALF > 1) ? $clog2(HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(HALF - 1);

  logic [CW-1:0] cnt_q;
  logic          mdc_q;
  logic          tick;

  assign tick   = run_i && (cnt_q == LAST);
  assign rise_o = tick && !mdc_q;
  assign fall_o = tick && mdc_q;
  assign mdc_o  = mdc_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (!run_i) begin
      cnt_q <= '0;
      mdc_q <= 1'b0;
    end else if (tick) begin
      cnt_q <= '0;
      mdc_q <= !mdc_q;
    end else begin
      cnt_q <= cnt_q + 1'b1;
    end
  end

  initial begin
    assert (CLK_DIV >= 2 && CLK_DIV % 2 == 0)
      else $error("CLK_DIV must be even and at least 2");
  end
endmodule

// File: rtl/mdio_shifter.sv
module mdio_shifter
  import mdio_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              start_i,
  input  mdio_cmd_t         cmd_i,
  input  logic              rise_i,
  input  logic              fall_i,
  input  logic              mdio_i,
  output logic              active_o,
  output logic              done_o,
  output logic              mdio_o,
  output logic              mdio_oe_o,
  output logic [DATA_W-1:0] rd_data_o
);
  logic [FRAME_LEN-1:0] frame_q;
  logic [FRAME_LEN-1:0] frame_d;
  logic [CNT_W-1:0]     bit_cnt_q;
  logic                 active_q;
  logic                 oe_q;
  logic                 rd_q;
  logic [DATA_W-1:0]    rd_sh_q;

  // preamble, start, opcode, addresses, turnaround, data
  assign frame_d = {32'hFFFF_FFFF, 2'b01, cmd_i.rd ? 2'b10 : 2'b01,
                    cmd_i.phy, cmd_i.regi, 2'b10,
                    cmd_i.rd ? {DATA_W{1'b1}} : cmd_i.data};

  assign done_o    = active_q && fall_i && (bit_cnt_q == CNT_W'(FRAME_LEN));
  assign active_o  = active_q;
  assign mdio_o    = active_q ? frame_q[FRAME_LEN-1] : 1'b1;
  assign mdio_oe_o = oe_q;
  assign rd_data_o = rd_sh_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      frame_q   <= '0;
      bit_cnt_q <= '0;
      active_q  <= 1'b0;
      oe_q      <= 1'b0;
      rd_q      <= 1'b0;
      rd_sh_q   <= '0;
    end else if (start_i) begin
      frame_q   <= frame_d;
      bit_cnt_q <= '0;
      active_q  <= 1'b1;
      oe_q      <= 1'b1;
      rd_q      <= cmd_i.rd;
      rd_sh_q   <= '0;
    end else if (active_q) begin
      if (rise_i) begin
        if (rd_q && bit_cnt_q >= CNT_W'(DATA_POS))
          rd_sh_q <= {rd_sh_q[DATA_W-2:0], mdio_i};
        bit_cnt_q <= bit_cnt_q + 1'b1;
      end
      if (fall_i) begin
        if (done_o) begin
          active_q <= 1'b0;
          oe_q     <= 1'b0;
        end else begin
          frame_q <= frame_q << 1;
          oe_q    <= !(rd_q && bit_cnt_q >= CNT_W'(TA_POS));
        end
      end
    end
  end

  assert_mdio_on_fall_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && $past(active_q) && !$stable(mdio_o) |-> $past(fall_i));

  assert_read_release_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    active_q && rd_q && bit_cnt_q >= CNT_W'(TA_POS + 1) |-> !mdio_oe_o);
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV  = 8,
  parameter int NUM_PHYS = 5
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        reg_wr_i,
  input  logic [31:0] reg_wdata_i,
  output logic [31:0] reg_rdata_o,
  output logic        mdc_o,
  output logic        mdio_o,
  output logic        mdio_oe_o,
  input  logic        mdio_i
);
  localparam logic [ADDR_W:0] PHY_LIMIT = (ADDR_W+1)'(NUM_PHYS);

  logic [DATA_W-1:0] data_q;
  logic [ADDR_W-1:0] reg_q;
  logic [ADDR_W-1:0] phy_q;
  logic              rd_q;
  logic              en_q;
  logic              busy_q;

  mdio_cmd_t         wcmd;
  logic              wr_ok;
  logic              start;
  logic              run;
  logic              rise;
  logic              fall;
  logic              done;
  logic [DATA_W-1:0] rd_data;

  assign wcmd.phy  = reg_wdata_i[PHY_LSB +: ADDR_W];
  assign wcmd.regi = reg_wdata_i[REG_LSB +: ADDR_W];
  assign wcmd.rd   = reg_wdata_i[RD_BIT];
  assign wcmd.data = reg_wdata_i[DATA_W-1:0];

  assign wr_ok = reg_wr_i && !busy_q;
  assign start = wr_ok && reg_wdata_i[BUSY_BIT] && reg_wdata_i[EN_BIT]
                 && ({1'b0, wcmd.phy} < PHY_LIMIT);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      data_q <= '0;
      reg_q  <= '0;
      phy_q  <= '0;
      rd_q   <= 1'b0;
      en_q   <= 1'b0;
      busy_q <= 1'b0;
    end else if (wr_ok) begin
      data_q <= wcmd.data;
      reg_q  <= wcmd.regi;
      phy_q  <= wcmd.phy;
      rd_q   <= wcmd.rd;
      en_q   <= reg_wdata_i[EN_BIT];
      busy_q <= start;
    end else if (done) begin
      busy_q <= 1'b0;
      if (rd_q) data_q <= rd_data;
    end
  end

  assign reg_rdata_o = {busy_q, en_q, 2'b00, rd_q, 1'b0, phy_q, reg_q, data_q};

  mdio_clk_div #(.CLK_DIV(CLK_DIV)) u_clk_div (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .run_i  (run),
    .mdc_o  (mdc_o),
    .rise_o (rise),
    .fall_o (fall)
  );

  mdio_shifter u_shifter (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .start_i   (start),
    .cmd_i     (wcmd),
    .rise_i    (rise),
    .fall_i    (fall),
    .mdio_i    (mdio_i),
    .active_o  (run),
    .done_o    (done),
    .mdio_o    (mdio_o),
    .mdio_oe_o (mdio_oe_o),
    .rd_data_o (rd_data)
  );

  assert_busy_clears_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done |=> !busy_q);

  assert_busy_frozen_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !done |=> busy_q && $stable({phy_q, reg_q, rd_q, en_q, data_q}));

  assert_no_start_disabled_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && reg_wr_i && !reg_wdata_i[EN_BIT] |=> !busy_q);

  assert_no_start_bad_phy_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && reg_wr_i && ({1'b0, reg_wdata_i[PHY_LSB +: ADDR_W]} >= PHY_LIMIT) |=> !busy_q);

  assert_mdc_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q |-> !mdc_o);
endmodule

// File: tb/mdio_master_tb.sv
`timescale 1ns/1ps
module mdio_master_tb;
  localparam int CLK_DIV  = 4;
  localparam int NUM_PHYS = 5;
  localparam int NVEC     = 6;
  localparam logic [63:0] OE_RD = 64'hFFFF_FFFF_FFFC_0000;

  // {control word, data returned by the PHY model}
  localparam logic [47:0] VEC [NVEC] = '{
    {32'hC000_1234, 16'h0000},
    {32'hC89F_0000, 16'hA5C3},
    {32'hC075_FFFF, 16'h0000},
    {32'hC822_0000, 16'h0001},
    {32'hC04A_8000, 16'h0000},
    {32'hC810_0000, 16'h8001}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        mdc, mdio_o, mdio_oe;
  logic        mdio_i = 1'b1;

  int tests = 0;
  int fails = 0;

  always #2 clk = !clk;

  mdio_master #(.CLK_DIV(CLK_DIV), .NUM_PHYS(NUM_PHYS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_wdata_i(reg_wdata),
    .reg_rdata_o(reg_rdata), .mdc_o(mdc), .mdio_o(mdio_o), .mdio_oe_o(mdio_oe),
    .mdio_i(mdio_i)
  );

  // PHY model
  int          rise_cnt = 0;
  int          base = 0;
  logic [15:0] phy_rd = '0;
  logic [63:0] cap_val, cap_oe;
  time         t_first, t_last;

  always @(posedge mdc) begin
    int idx;
    idx = rise_cnt - base;
    if (idx >= 0 && idx < 64) begin
      cap_val[63-idx] = mdio_o;
      cap_oe[63-idx]  = mdio_oe;
      if (idx == 0)  t_first = $time;
      if (idx == 63) t_last  = $time;
    end
    rise_cnt = rise_cnt + 1;
  end

  always @(negedge mdc) begin
    int idx;
    idx = rise_cnt - base;
    mdio_i = (idx >= 48 && idx <= 63) ? phy_rd[63-idx] : 1'b1;
  end

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [31:0] w);
    @(negedge clk);
    reg_wr = 1'b1;
    reg_wdata = w;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic wait_idle();
    for (int i = 0; i < 20000; i++) begin
      if (!reg_rdata[31]) break;
      @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [63:0] exp_frame(input logic [31:0] c);
    return {32'hFFFF_FFFF, 2'b01, c[27] ? 2'b10 : 2'b01, c[25:21], c[20:16], 2'b10, c[15:0]};
  endfunction

  task automatic run_frame(input logic [31:0] c, input logic [15:0] rdv);
    logic [63:0] m, ef;
    logic [31:0] er;
    phy_rd = rdv;
    base = rise_cnt;
    wr(c);
    chk(reg_rdata[31] == 1'b1, "R2 busy after start", 64'(reg_rdata), 64'(c));
    wait_idle();
    m  = c[27] ? OE_RD : '1;
    ef = exp_frame(c);
    chk((rise_cnt - base) == 64, "R3 frame length", 64'(rise_cnt - base), 64);
    chk((cap_val & m) == (ef & m), c[27] ? "R3 read header" : "R4 write frame", cap_val & m, ef & m);
    chk(cap_oe == m, c[27] ? "R5 read release" : "R4 write drive", cap_oe, m);
    chk((t_last - t_first) == 63 * CLK_DIV * 4, "R8 mdc period",
        64'(t_last - t_first), 64'(63 * CLK_DIV * 4));
    er = c[27] ? {1'b0, c[30:16], rdv} : {1'b0, c[30:0]};
    chk(reg_rdata == er, c[27] ? "R6 read data" : "R7 busy clear", 64'(reg_rdata), 64'(er));
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    fails++;
    tests++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    logic [31:0] c0;
    repeat (3) @(negedge clk);
    chk(reg_rdata == 32'h0 && !mdc && !mdio_oe, "R1 reset state",
        {reg_rdata, 30'h0, mdc, mdio_oe}, 64'h0);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);

    for (int i = 0; i < NVEC; i++) run_frame(VEC[i][47:16], VEC[i][15:0]);

    // R9: write during a frame is dropped
    c0 = 32'hC023_BEEF;
    phy_rd = '0;
    base = rise_cnt;
    wr(c0);
    repeat (100) @(negedge clk);
    wr(32'hC89F_0000);
    chk(reg_rdata == c0, "R9 word frozen while busy", 64'(reg_rdata), 64'(c0));
    wait_idle();
    chk((rise_cnt - base) == 64, "R9 frame length unchanged", 64'(rise_cnt - base), 64);
    chk(cap_val == exp_frame(c0) && cap_oe == '1, "R9 frame unchanged", cap_val, exp_frame(c0));
    chk(reg_rdata == {1'b0, c0[30:0]}, "R9 final word", 64'(reg_rdata), 64'({1'b0, c0[30:0]}));

    // R10: start with enable clear
    base = rise_cnt;
    wr(32'h8000_1234);
    chk(reg_rdata == 32'h0000_1234, "R10 no busy when disabled", 64'(reg_rdata), 64'h1234);
    repeat (60) @(negedge clk);
    chk(rise_cnt == base && !mdc, "R10 no mdc edge", 64'(rise_cnt - base), 0);

    // R11: illegal PHY address 5 (highest legal is 4, covered above)
    wr(32'hC0A0_0000);
    chk(reg_rdata == 32'h40A0_0000, "R11 no busy on bad phy", 64'(reg_rdata), 64'h40A0_0000);
    repeat (60) @(negedge clk);
    chk(rise_cnt == base && !mdc, "R11 no mdc edge", 64'(rise_cnt - base), 0);

    // R12: plain field write
    wr(32'h4811_5555);
    chk(reg_rdata == 32'h4811_5555, "R12 fields stored", 64'(reg_rdata), 64'h4811_5555);
    repeat (60) @(negedge clk);
    chk(rise_cnt == base && !mdc && !mdio_oe, "R12 no frame", 64'(rise_cnt - base), 0);

    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule